// File: doc/BRIEF.md
# Sticky Low-Event Capture with Serial Readout

This block watches a bank of digital lines that idle high. It records, for each line, whether the line dropped low at any time during a monitoring period. Every line has its own sticky flag. The flag is set by a low level and stays set until the host clears it. The host reads the flags over three slow control wires and one data wire. A load strobe freezes a copy of all flags into a shift register. Each shift-clock edge then moves the next channel onto the serial data output, starting from the highest-numbered channel. After reading, the host issues a clear request, and a new period begins.

Capture never pauses. Events that arrive while a snapshot is being shifted out still set the live flags, and the copy in flight does not change. All host control wires are asynchronous to the system clock. Each one passes through a two-stage synchronizer and a rising-edge detector, so one host edge causes exactly one action. The monitored lines are synchronized in the same way.

Top module: `lowcap_top`

## Requirements
- R1: Each of the 64 channels is independent. A low level on a line that lasts at least two system clock cycles sets that channel's flag and no other.
- R2: Once set, a flag stays set after the line returns high, until a clear request is seen.
- R3: A rising edge on `load_i` copies all 64 flags into the snapshot register in one clock. Immediately afterwards, `sdo_o` shows channel 63. A new load during an ongoing readout restarts the sequence at channel 63.
- R4: Each rising edge on `sclk_i` advances `sdo_o` to the next lower channel, so channel 0 appears after 63 edges. Further edges present 0.
- R5: A rising edge on `clear_i` resets every flag in one clock, except that a channel whose line is low in that cycle stays set.
- R6: While a snapshot is being shifted out, new low events set the live flags but leave the snapshot unchanged. Those events appear in the next readout.
- R7: Host controls are synchronized and edge-detected. Holding `sclk_i` high for many clock cycles causes exactly one shift. A control edge takes effect on the third rising system clock edge after the input changes.
- R8: A synchronous active-high `rst` clears all flags and the snapshot and drives `sdo_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lines_i | input | 64 | Monitored lines, idle high, event on low |
| load_i | input | 1 | Host strobe; rising edge snapshots all flags |
| sclk_i | input | 1 | Host shift clock; rising edge advances one channel |
| clear_i | input | 1 | Host request; rising edge clears the flags |
| sdo_o | output | 1 | Serial data; snapshot bit of the current channel |

## Verification
The hardest situations to reach are those where a host action coincides with line activity. One is a clear request that lands while a line is still held low. The other is an event that arrives halfway through a readout, on a channel that has not yet been shifted out. The stimulus handles the first by holding one line low across the whole clear pulse and releasing it only afterwards. It handles the second by stopping the shift loop after about thirty edges, pulling a lower-numbered channel low, and then finishing the readout. The readout must show the old value, and a second full readout must show the new event.

// File: rtl/lowcap_pkg.sv
package lowcap_pkg;
  localparam int unsigned CH_COUNT    = 64;
  localparam int unsigned SYNC_DEPTH  = 2;
  localparam int unsigned HOST_N      = 3;
  // positions of the host controls in the synchronized control vector
  localparam int unsigned HC_LOAD     = 0;
  localparam int unsigned HC_SHIFT    = 1;
  localparam int unsigned HC_CLEAR    = 2;
endpackage

// File: rtl/lowcap_sync.sv
module lowcap_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= {WIDTH{RST_VAL}};
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/lowcap_host_edge.sv
module lowcap_host_edge #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] pulse
);
  logic [WIDTH-1:0] synced;
  logic [WIDTH-1:0] prev;

  lowcap_sync #(.WIDTH(WIDTH), .STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= synced;
  end

  assign pulse = synced & ~prev;

  // one host edge yields a single-cycle pulse, never two in a row
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |=> ((pulse & $past(pulse)) == '0));
endmodule

// File: rtl/lowcap_flags.sv
module lowcap_flags #(
  parameter int unsigned CH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] seen_low,
  input  logic          clr,
  output logic [CH-1:0] flags
);
  for (genvar i = 0; i < CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= (flags[i] & ~clr) | seen_low[i];
    end
  end

  // a set flag survives every cycle without a clear
  assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  // after a clear only channels that were low during it remain set
  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    clr |=> ((flags & ~$past(seen_low)) == '0));

  // a flag only rises when its own line was seen low
  assert_set_cause_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(seen_low)) == '0));
endmodule

// File: rtl/lowcap_shifter.sv
module lowcap_shifter #(
  parameter int unsigned CH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] flags_in,
  input  logic          load,
  input  logic          shift,
  output logic          sdo
);
  logic [CH-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst)        snap <= '0;
    else if (load)  snap <= flags_in;
    else if (shift) snap <= {snap[CH-2:0], 1'b0};
  end

  assign sdo = snap[CH-1];

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (snap == $past(flags_in)));

  assert_shift_next_R4: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (sdo == $past(snap[CH-2])));

  // live flag activity never reaches the snapshot between host actions
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!shift && !load) |=> $stable(snap));

  assert_reset_low_R8: assert property (@(posedge clk)
    rst |=> (!sdo && snap == '0));
endmodule

// File: rtl/lowcap_top.sv
module lowcap_top
  import lowcap_pkg::*;
#(
  parameter int unsigned CH     = CH_COUNT,
  parameter int unsigned STAGES = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] lines_i,
  input  logic          load_i,
  input  logic          sclk_i,
  input  logic          clear_i,
  output logic          sdo_o
);
  logic [CH-1:0]     lines_s;
  logic [CH-1:0]     flags;
  logic [HOST_N-1:0] host_raw;
  logic [HOST_N-1:0] host_pulse;

  // lines idle high, so the synchronizer resets to high to avoid false events
  lowcap_sync #(.WIDTH(CH), .STAGES(STAGES), .RST_VAL(1'b1)) u_line_sync (
    .clk(clk), .rst(rst), .d(lines_i), .q(lines_s)
  );

  always_comb begin
    host_raw           = '0;
    host_raw[HC_LOAD]  = load_i;
    host_raw[HC_SHIFT] = sclk_i;
    host_raw[HC_CLEAR] = clear_i;
  end

  lowcap_host_edge #(.WIDTH(HOST_N), .STAGES(STAGES)) u_host (
    .clk(clk), .rst(rst), .raw(host_raw), .pulse(host_pulse)
  );

  lowcap_flags #(.CH(CH)) u_flags (
    .clk(clk), .rst(rst), .seen_low(~lines_s),
    .clr(host_pulse[HC_CLEAR]), .flags(flags)
  );

  lowcap_shifter #(.CH(CH)) u_shift (
    .clk(clk), .rst(rst), .flags_in(flags),
    .load(host_pulse[HC_LOAD]), .shift(host_pulse[HC_SHIFT]), .sdo(sdo_o)
  );
endmodule

// File: tb/sim_lowcap_top.sv
module sim_lowcap_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] lines = '1;
  logic        load = 1'b0, sclk = 1'b0, clr = 1'b0;
  logic        sdo;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk; // 50 MHz

  lowcap_top u0 (
    .clk(clk), .rst(rst), .lines_i(lines), .load_i(load),
    .sclk_i(sclk), .clear_i(clr), .sdo_o(sdo)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load();  load = 1; wait_n(4); load = 0; wait_n(4); endtask
  task automatic pulse_shift(); sclk = 1; wait_n(4); sclk = 0; wait_n(4); endtask
  task automatic pulse_clear(); clr  = 1; wait_n(4); clr  = 0; wait_n(4); endtask

  task automatic drop_line(input int idx, input int cyc);
    lines[idx] = 1'b0; wait_n(cyc); lines[idx] = 1'b1; wait_n(4);
  endtask

  task automatic read_all(output logic [63:0] v);
    pulse_load();
    v[63] = sdo;
    for (int i = 62; i >= 0; i--) begin
      pulse_shift();
      v[i] = sdo;
    end
  endtask

  task automatic t_reset();
    logic [63:0] v;
    chk(sdo == 1'b0, "R8 sdo in reset", {63'd0, sdo}, 64'd0);
    rst = 0; wait_n(2);
    read_all(v);
    chk(v == '0, "R8 flags after reset", v, 64'd0);
  endtask

  task automatic t_pattern();
    logic [63:0] v;
    drop_line(0, 3); drop_line(5, 2); drop_line(63, 2);
    read_all(v);
    chk(v == 64'h8000_0000_0000_0021, "R1 independent channels", v, 64'h8000_0000_0000_0021);
    read_all(v);
    chk(v == 64'h8000_0000_0000_0021, "R2 sticky after release", v, 64'h8000_0000_0000_0021);
    pulse_shift();
    chk(sdo == 1'b0, "R4 shift past channel 0 gives 0", {63'd0, sdo}, 64'd0);
    pulse_clear();
    read_all(v);
    chk(v == '0, "R5 clear resets all", v, 64'd0);
  endtask

  task automatic t_clear_held();
    logic [63:0] v;
    drop_line(20, 2); drop_line(41, 2);
    lines[7] = 1'b0; wait_n(4);
    pulse_clear();
    lines[7] = 1'b1; wait_n(4);
    read_all(v);
    chk(v == 64'h80, "R5 held-low channel survives clear", v, 64'h80);
    pulse_clear();
  endtask

  task automatic t_hold_and_reload();
    logic [63:0] v;
    drop_line(63, 2); drop_line(61, 2);
    pulse_load();
    chk(sdo == 1'b1, "R3 channel 63 first", {63'd0, sdo}, 64'd1);
    sclk = 1; wait_n(20);
    chk(sdo == 1'b0, "R7 long sclk high shifts once", {63'd0, sdo}, 64'd0);
    sclk = 0; wait_n(4);
    pulse_shift();
    chk(sdo == 1'b1, "R7 next edge gives channel 61", {63'd0, sdo}, 64'd1);
    pulse_load();
    chk(sdo == 1'b1, "R3 reload restarts at 63", {63'd0, sdo}, 64'd1);
    pulse_shift();
    chk(sdo == 1'b0, "R4 second bit after reload", {63'd0, sdo}, 64'd0);
    pulse_clear();
  endtask

  task automatic t_latency();
    drop_line(63, 2);
    load = 1;
    @(negedge clk); @(negedge clk);
    chk(sdo == 1'b0, "R7 no effect before third edge", {63'd0, sdo}, 64'd0);
    @(negedge clk);
    chk(sdo == 1'b1, "R7 effect at third edge", {63'd0, sdo}, 64'd1);
    load = 0; wait_n(4);
    pulse_clear();
  endtask

  task automatic t_during_shift();
    logic [63:0] v;
    drop_line(10, 2);
    pulse_load();
    v[63] = sdo;
    for (int i = 62; i >= 0; i--) begin
      if (i == 30) drop_line(20, 3);
      pulse_shift();
      v[i] = sdo;
    end
    chk(v == 64'h400, "R6 snapshot unaffected by new event", v, 64'h400);
    read_all(v);
    chk(v == 64'h10_0400, "R6 new event in next readout", v, 64'h10_0400);
  endtask

  task automatic t_reset_mid();
    logic [63:0] v;
    drop_line(63, 2);
    pulse_load();
    rst = 1; wait_n(2);
    chk(sdo == 1'b0, "R8 sdo low on reset", {63'd0, sdo}, 64'd0);
    rst = 0; wait_n(2);
    read_all(v);
    chk(v == '0, "R8 reset clears flags", v, 64'd0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    t_pattern();
    t_clear_held();
    t_hold_and_reload();
    t_latency();
    t_during_shift();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule